// File: doc/BRIEF.md
# Color Correction Matrix Engine

The block sits in a pixel pipeline and recolours each pixel by multiplying its red, green and blue components with a programmable 3x3 matrix. Pixels arrive and leave on a valid/ready stream that also carries a start-of-frame flag and an end-of-line flag. The flags travel with their pixel. Each output component is computed from all three input components. The result is rounded to the nearest integer and then clamped to the legal component range.

Software controls the block through a small write/read register port. The registers hold a global run bit, a configuration word, the frame dimensions and the nine matrix coefficients, packed two to a 32-bit word. Each coefficient is sign-magnitude. A parameter sets its fraction width n, and a magnitude of 2^n means a gain of 1.0. A relay setting, or a clear engine-enable bit, makes the block pass pixels through untouched. Pass-through pixels keep the same latency as computed ones. A new matrix is adopted only when a start-of-frame pixel is accepted, so no frame mixes two matrices.

Top module: `ccm_engine`

## Requirements
- R1: After reset, every register reads 0, `out_valid_o` is 0 and `in_ready_o` is 0.
- R2: Register map and read-back.
  - 0x00: the run bit is bit 0, and the other bits read 0.
  - 0x20: the configuration word. Bit 0 is relay and bit 1 is engine enable. Bits 2 and 3 are stored but have no effect, and bits above 3 read 0.
  - 0x30: the frame size, all 32 bits stored.
  - 0x80, 0x84, 0x88, 0x8C and 0x90: coefficient words, with the low half of 0x90 reading 0.
  - Any other address reads 0.
- R3: While the run bit is 0, `in_ready_o` is 0, no pixel is accepted and no output appears.
- R4: Coefficient words are laid out as follows.
  - The word at 0x80+4k holds coefficient 2k in bits 31:16 and coefficient 2k+1 in bits 15:0.
  - Coefficient 8 is bits 31:16 of 0x90.
  - Within a 16-bit field, bit n+1 is the sign (1 = negative) and bits n..0 are the magnitude. Field bits above n+1 are ignored.
- R5: With row-major coefficients c0..c8, the outputs are: out_r from c0·R + c1·G + c2·B, out_g from c3·R + c4·G + c5·B, and out_b from c6·R + c7·G + c8·B.
- R6: Each signed sum has 2^(n-1) added and is then shifted right arithmetically by n, so halves round upward.
- R7: A negative result outputs 0, and a result above 2^DATA_W-1 outputs 2^DATA_W-1.
- R8: When relay (bit 0) is 1 or engine enable (bit 1) is 0, the output pixel equals the input pixel.
- R9: Timing and flags.
  - A pixel accepted at clock edge k is presented with `out_valid_o` high right after edge k+1, provided `out_ready_i` is high.
  - Its start-of-frame and end-of-line flags come out with it.
- R10: Stall behaviour.
  - While `out_valid_o` is 1 and `out_ready_i` is 0, the output pixel and flags hold.
  - At most two pixels are in flight.
  - Every accepted pixel leaves exactly once, in order.
- R11: Matrix adoption.
  - The matrix in use is loaded from the coefficient registers when a start-of-frame pixel is accepted.
  - That pixel already uses the new matrix.
  - Coefficient writes made at any other time leave the output unchanged until the next start of frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Input pixel accepted when high with valid |
| in_sof_i | input | 1 | Input start-of-frame flag |
| in_eol_i | input | 1 | Input end-of-line flag |
| in_r_i | input | DATA_W | Input red |
| in_g_i | input | DATA_W | Input green |
| in_b_i | input | DATA_W | Input blue |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream ready |
| out_sof_o | output | 1 | Output start-of-frame flag |
| out_eol_o | output | 1 | Output end-of-line flag |
| out_r_o | output | DATA_W | Output red |
| out_g_o | output | DATA_W | Output green |
| out_b_o | output | DATA_W | Output blue |

## Verification
The bench builds the engine with 8-bit components and a fraction width of n = 10, so 1.0 is 0x400 and the sign sits at bit 11. With n = 10, halves, quarters and 1.5 are exact coefficients. The hand-computed expectations therefore land on exact .5 sums, which tests upward rounding. Mixing a negative coefficient with a 1.5 gain drives results both below zero and above 255. The maximum magnitude 0x7FF and 16-bit fields with bits above the sign set test field decoding at the edge of the format.

// File: rtl/ccm_pkg.sv
`timescale 1ns/1ps
package ccm_pkg;
  localparam int REG_AW       = 8;
  localparam int BUS_W        = 32;
  localparam int HALF_W       = 16;
  localparam int CFG_W        = 4;
  localparam int NUM_COEF     = 9;
  localparam int NUM_COEF_REG = (NUM_COEF + 1) / 2;
  localparam int CFG_RELAY    = 0;
  localparam int CFG_ENGINE   = 1;

  typedef logic [REG_AW-1:0] reg_addr_t;
  typedef logic [BUS_W-1:0]  reg_word_t;

  localparam reg_addr_t ADR_RUN   = 8'h00;
  localparam reg_addr_t ADR_CFG   = 8'h20;
  localparam reg_addr_t ADR_SIZE  = 8'h30;
  localparam reg_addr_t ADR_COEF0 = 8'h80;
endpackage

// File: rtl/ccm_regs.sv
`timescale 1ns/1ps
module ccm_regs
  import ccm_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  reg_addr_t                    addr_i,
  input  reg_word_t                    wdata_i,
  output reg_word_t                    rdata_o,
  output logic                         run_o,
  output logic                         bypass_o,
  output logic [NUM_COEF-1:0][CW-1:0]  coef_o
);
  logic                            run_q;
  logic [CFG_W-1:0]                cfg_q;
  reg_word_t                       size_q;
  logic [NUM_COEF-1:0][HALF_W-1:0] field_q;
  reg_word_t                       word_rd [NUM_COEF_REG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cfg_q  <= '0;
      size_q <= '0;
    end else if (we_i) begin
      if (addr_i == ADR_RUN)  run_q  <= wdata_i[0];
      if (addr_i == ADR_CFG)  cfg_q  <= wdata_i[CFG_W-1:0];
      if (addr_i == ADR_SIZE) size_q <= wdata_i;
    end
  end

  for (genvar j = 0; j < NUM_COEF; j++) begin : g_field
    localparam reg_addr_t FADR = ADR_COEF0 + REG_AW'(4 * (j / 2));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) field_q[j] <= '0;
      else if (we_i && addr_i == FADR)
        field_q[j] <= (j % 2 == 0) ? wdata_i[BUS_W-1:HALF_W] : wdata_i[HALF_W-1:0];
    end
    assign coef_o[j] = field_q[j][CW-1:0];
  end

  for (genvar k = 0; k < NUM_COEF_REG; k++) begin : g_word
    if (2 * k + 1 < NUM_COEF) begin : g_pair
      assign word_rd[k] = {field_q[2*k], field_q[2*k+1]};
    end else begin : g_single
      assign word_rd[k] = {field_q[2*k], {HALF_W{1'b0}}};
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADR_RUN)  rdata_o = {{(BUS_W-1){1'b0}}, run_q};
    if (addr_i == ADR_CFG)  rdata_o = {{(BUS_W-CFG_W){1'b0}}, cfg_q};
    if (addr_i == ADR_SIZE) rdata_o = size_q;
    for (int k = 0; k < NUM_COEF_REG; k++)
      if (addr_i == ADR_COEF0 + REG_AW'(4 * k)) rdata_o = word_rd[k];
  end

  assign run_o    = run_q;
  assign bypass_o = cfg_q[CFG_RELAY] | ~cfg_q[CFG_ENGINE];
endmodule

// File: rtl/ccm_mac.sv
`timescale 1ns/1ps
module ccm_mac #(
  parameter int DATA_W = 8,
  parameter int FRAC_N = 10
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          adv_i,
  input  logic                          bypass_i,
  input  logic [2:0][DATA_W-1:0]        pix_i,
  input  logic [2:0][FRAC_N+1:0]        coef_i,
  input  logic [DATA_W-1:0]             byp_pix_i,
  output logic [DATA_W-1:0]             res_o
);
  localparam int CW   = FRAC_N + 2;
  localparam int PW   = DATA_W + 1 + CW;
  localparam int SW   = PW + 2;
  localparam int MAXV = (1 << DATA_W) - 1;
  localparam logic signed [SW-1:0] HALF = SW'(1 << (FRAC_N - 1));

  logic signed [PW-1:0] prod_d [3];
  logic signed [PW-1:0] prod_q [3];
  logic [DATA_W-1:0]    byp_q, res_q, clip;
  logic                 bsel_q;
  logic signed [SW-1:0] sum, shr;

  for (genvar t = 0; t < 3; t++) begin : g_term
    logic [FRAC_N:0]        mag;
    logic signed [CW-1:0]   cval;
    logic signed [DATA_W:0] pval;
    assign mag  = coef_i[t][FRAC_N:0];
    assign cval = coef_i[t][CW-1] ? -signed'({1'b0, mag}) : signed'({1'b0, mag});
    assign pval = signed'({1'b0, pix_i[t]});
    assign prod_d[t] = PW'(pval) * PW'(cval);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '{default: '0};
      byp_q  <= '0;
      bsel_q <= 1'b0;
      res_q  <= '0;
    end else if (adv_i) begin
      prod_q <= prod_d;
      byp_q  <= byp_pix_i;
      bsel_q <= bypass_i;
      res_q  <= bsel_q ? byp_q : clip;
    end
  end

  always_comb begin
    sum = SW'(prod_q[0]) + SW'(prod_q[1]) + SW'(prod_q[2]) + HALF;
    shr = sum >>> FRAC_N;
    if (shr < 0)                   clip = '0;
    else if (shr > SW'(MAXV))      clip = DATA_W'(MAXV);
    else                           clip = shr[DATA_W-1:0];
  end

  assign res_o = res_q;
endmodule

// File: rtl/ccm_engine.sv
`timescale 1ns/1ps
module ccm_engine
  import ccm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FRAC_N = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              in_sof_i,
  input  logic              in_eol_i,
  input  logic [DATA_W-1:0] in_r_i,
  input  logic [DATA_W-1:0] in_g_i,
  input  logic [DATA_W-1:0] in_b_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_sof_o,
  output logic              out_eol_o,
  output logic [DATA_W-1:0] out_r_o,
  output logic [DATA_W-1:0] out_g_o,
  output logic [DATA_W-1:0] out_b_o
);
  localparam int CW = FRAC_N + 2;

  logic                        run_w, bypass_w, adv, in_fire, sof_take;
  logic [NUM_COEF-1:0][CW-1:0] prog_coef, act_q, cur_coef;
  logic                        v1_q, v2_q, sof1_q, eol1_q, sof2_q, eol2_q;
  logic [2:0][DATA_W-1:0]      pix_in, pix_out;

  ccm_regs #(.CW(CW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .run_o    (run_w),
    .bypass_o (bypass_w),
    .coef_o   (prog_coef)
  );

  assign adv        = ~v2_q | out_ready_i;
  assign in_ready_o = run_w & adv;
  assign in_fire    = in_valid_i & in_ready_o;
  assign sof_take   = in_fire & in_sof_i;
  // start-of-frame pixel already sees the freshly adopted matrix
  assign cur_coef   = sof_take ? prog_coef : act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else if (sof_take) act_q <= prog_coef;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {v1_q, v2_q, sof1_q, eol1_q, sof2_q, eol2_q} <= '0;
    end else if (adv) begin
      v1_q   <= in_fire;
      sof1_q <= in_sof_i;
      eol1_q <= in_eol_i;
      v2_q   <= v1_q;
      sof2_q <= sof1_q;
      eol2_q <= eol1_q;
    end
  end

  assign pix_in = {in_b_i, in_g_i, in_r_i};

  for (genvar i = 0; i < 3; i++) begin : g_row
    ccm_mac #(.DATA_W(DATA_W), .FRAC_N(FRAC_N)) u_mac (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .adv_i     (adv),
      .bypass_i  (bypass_w),
      .pix_i     (pix_in),
      .coef_i    (cur_coef[3*i+2 : 3*i]),
      .byp_pix_i (pix_in[i]),
      .res_o     (pix_out[i])
    );
  end

  assign out_valid_o = v2_q;
  assign out_sof_o   = sof2_q;
  assign out_eol_o   = eol2_q;
  assign out_r_o     = pix_out[0];
  assign out_g_o     = pix_out[1];
  assign out_b_o     = pix_out[2];
endmodule

// File: rtl/ccm_engine_chk.sv
`timescale 1ns/1ps
module ccm_engine_chk #(
  parameter int DATA_W = 8,
  parameter int CW     = 12
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                in_valid_i,
  input logic                in_ready_o,
  input logic                in_sof_i,
  input logic                out_valid_o,
  input logic                out_ready_i,
  input logic                out_sof_o,
  input logic                out_eol_o,
  input logic [DATA_W-1:0]   out_r_o,
  input logic [DATA_W-1:0]   out_g_o,
  input logic [DATA_W-1:0]   out_b_o,
  input logic                run_i,
  input logic [9*CW-1:0]     act_i
);
  logic [2:0] inflight;
  logic       in_f, out_f;
  assign in_f  = in_valid_i & in_ready_o;
  assign out_f = out_valid_o & out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight <= '0;
    else inflight <= inflight + 3'(in_f) - 3'(out_f);
  end

  AST_NO_ACCEPT_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !in_ready_o); // R3

  AST_HOLD_ON_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o &&
      $stable({out_sof_o, out_eol_o, out_r_o, out_g_o, out_b_o})); // R10

  AST_INFLIGHT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight <= 3'd2); // R10

  AST_VALID_HAS_PIXEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> inflight != 3'd0); // R10

  AST_MATRIX_AT_SOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_f && in_sof_i) |=> $stable(act_i)); // R11
endmodule

bind ccm_engine ccm_engine_chk #(.DATA_W(DATA_W), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_sof_i    (in_sof_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_sof_o   (out_sof_o),
  .out_eol_o   (out_eol_o),
  .out_r_o     (out_r_o),
  .out_g_o     (out_g_o),
  .out_b_o     (out_b_o),
  .run_i       (run_w),
  .act_i       (act_q)
);

// File: tb/ccm_engine_bench.sv
`timescale 1ns/1ps
module ccm_engine_bench;
  localparam int DATA_W = 8;
  localparam int FRAC_N = 10;
  localparam int NV = 6;
  // r, g, b, exp_r, exp_g, exp_b  (matrix: [1,0,0; .5,.5,0; -.25,0,1.5])
  localparam int VEC [NV][6] = '{
    '{ 10,  20,  30,  10,  15,  43},
    '{255, 255, 255, 255, 255, 255},
    '{200,   0,  10, 200, 100,   0},
    '{  3,   0,   2,   3,   2,   2},
    '{  0,   1,   0,   0,   1,   0},
    '{  1,   0,   1,   1,   1,   1}
  };
  localparam int ADRS [8] = '{'h00, 'h20, 'h30, 'h80, 'h84, 'h88, 'h8C, 'h90};

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic in_valid = 1'b0, in_ready, in_sof = 1'b0, in_eol = 1'b0;
  logic [DATA_W-1:0] in_r = '0, in_g = '0, in_b = '0;
  logic out_valid, out_ready = 1'b1, out_sof, out_eol;
  logic [DATA_W-1:0] out_r, out_g, out_b;
  int total = 0, bad = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  ccm_engine #(.DATA_W(DATA_W), .FRAC_N(FRAC_N)) u_ccm_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_sof_i(in_sof), .in_eol_i(in_eol),
    .in_r_i(in_r), .in_g_i(in_g), .in_b_i(in_b),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_sof_o(out_sof), .out_eol_o(out_eol),
    .out_r_o(out_r), .out_g_o(out_g), .out_b_o(out_b)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = 8'(a); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); addr = 8'(a); #1; d = rdata;
  endtask

  // one pixel, out_ready high: result visible after the second edge
  task automatic xfer(input string req, input int r, input int g, input int b,
                      input bit sof, input bit eol,
                      input int er, input int eg, input int eb);
    @(negedge clk);
    in_valid = 1'b1; in_sof = sof; in_eol = eol;
    in_r = DATA_W'(r); in_g = DATA_W'(g); in_b = DATA_W'(b);
    chk("R3 ready while running", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
    chk("R9 not valid one edge after accept", out_valid, 0);
    @(negedge clk);
    chk("R9 valid two edges after accept", out_valid, 1);
    chk("R9 sof travels", out_sof, sof);
    chk("R9 eol travels", out_eol, eol);
    chk({req, " red"}, out_r, er);
    chk({req, " green"}, out_g, eg);
    chk({req, " blue"}, out_b, eb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 in_ready after reset", in_ready, 0);
    for (int i = 0; i < 8; i++) begin
      rd(ADRS[i], rv);
      chk("R1 register reads zero", rv, 0);
    end

    // R2 register map
    wr('h20, 32'hFFFF_FFFF); rd('h20, rv); chk("R2 cfg width", rv, 32'h0000_000F);
    wr('h00, 32'hFFFF_FFFF); rd('h00, rv); chk("R2 run bit only", rv, 1);
    wr('h30, 32'h0780_0438); rd('h30, rv); chk("R2 size", rv, 32'h0780_0438);
    wr('h90, 32'hFFFF_FFFF); rd('h90, rv); chk("R2 last coef low half", rv, 32'hFFFF_0000);
    wr('h84, 32'h1234_5678); rd('h84, rv); chk("R2 coef word", rv, 32'h1234_5678);
    wr('h40, 32'hFFFF_FFFF); rd('h40, rv); chk("R2 unmapped", rv, 0);

    // R3 stop
    wr('h00, 0);
    @(negedge clk); in_valid = 1'b1; in_sof = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R3 ready low while stopped", in_ready, 0);
      chk("R3 no output while stopped", out_valid, 0);
    end
    in_valid = 1'b0; in_sof = 1'b0;

    // program matrix, engine on
    wr('h80, 32'h0400_0000);
    wr('h84, 32'h0000_0200);
    wr('h88, 32'h0200_0000);
    wr('h8C, 32'h0900_0000);
    wr('h90, 32'h0600_0000);
    wr('h20, 32'h2);
    wr('h00, 32'h1);

    // R5 R6 R7 vector table
    for (int i = 0; i < NV; i++)
      xfer("R5 R6 R7 table", VEC[i][0], VEC[i][1], VEC[i][2], i == 0, i == NV - 1,
           VEC[i][3], VEC[i][4], VEC[i][5]);

    // R11 shadowing: write mid-frame, old matrix persists until sof
    wr('h80, 32'h0200_0000);
    xfer("R11 old matrix mid-frame", 10, 20, 30, 1'b0, 1'b0, 10, 15, 43);
    xfer("R11 new matrix at sof", 10, 20, 30, 1'b1, 1'b0, 5, 15, 43);

    // R4 field decode: upper bits ignored, max magnitude 0x7FF
    wr('h80, 32'hF7FF_0000);
    xfer("R4 max magnitude upper bits ignored", 100, 0, 0, 1'b1, 1'b0, 200, 50, 0);
    wr('h80, 32'h0400_0000);

    // R8 bypass
    wr('h20, 32'h3);
    xfer("R8 relay", 200, 0, 10, 1'b1, 1'b1, 200, 0, 10);
    wr('h20, 32'h0);
    xfer("R8 engine off", 7, 8, 9, 1'b0, 1'b0, 7, 8, 9);
    wr('h20, 32'h2);
    xfer("R5 restored matrix", 40, 0, 0, 1'b1, 1'b0, 40, 20, 0);

    // R10 stall
    @(negedge clk); out_ready = 1'b0;
    in_valid = 1'b1; in_r = 8'd11; in_g = '0; in_b = '0;
    chk("R10 accept first", in_ready, 1);
    @(negedge clk); in_r = 8'd12;
    chk("R10 accept second", in_ready, 1);
    @(negedge clk); in_r = 8'd13;
    chk("R10 full blocks input", in_ready, 0);
    chk("R10 head valid", out_valid, 1);
    chk("R10 head value", out_r, 11);
    @(negedge clk);
    chk("R10 head held", out_r, 11);
    chk("R10 still blocked", in_ready, 0);
    out_ready = 1'b1;
    #1 chk("R10 ready on release", in_ready, 1);
    @(negedge clk); in_valid = 1'b0;
    chk("R10 second out", out_r, 12);
    chk("R10 second valid", out_valid, 1);
    @(negedge clk);
    chk("R10 third out", out_r, 13);
    chk("R10 third valid", out_valid, 1);
    @(negedge clk);
    chk("R10 no duplicate", out_valid, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule